// File: doc/BRIEF.md
# Link Training Read FIFO

This block is a small pattern store used while a high-speed memory-style interface trains its read and write data paths. A controller sends it commands on a command strobe. A load command writes one beat of a pattern that arrives on the address bus. A write-training command puts a whole captured write burst straight into storage. A play command sends one stored entry back out on the read data port after a programmable number of cycles.

Storage is a ring of six entries. Each entry is one burst of eight beats across every data lane, which is 256 bits for a 32-lane build. Separate write and read pointers move around the ring. Reading never clears an entry, so a pattern that has been stored once can be replayed as often as needed. Commands pass through one decode register. The play latency is counted from the clock edge that samples the command.

Top module: `lt_read_fifo`

## Requirements
- R1: While reset is asserted and just after it is released, both pointers are at entry 0 and rd_vld is low. Entry contents are kept through reset, but they are undefined until something writes them.
- R2: A write-training command (cmd_vld=1, cmd_op=2'b10) stores all of wr_data into the entry at the write pointer. Beat b of lane i is bit b*LANES+i. The write pointer then advances by one.
- R3: A load command (cmd_vld=1, cmd_op=2'b01) writes beat cmd_beat of the entry at the write pointer. Lane i of that beat gets cmd_addr[i mod ADDR_W]. All other beats of the entry are left unchanged.
- R4: A load command advances the write pointer only when cmd_beat equals BURST-1. A load to any other beat leaves the write pointer where it is.
- R5: A play command (cmd_vld=1, cmd_op=2'b11) returns the entry at the read pointer on rd_data, and the read pointer advances by one. Back-to-back play commands return consecutive entries.
- R6: Both pointers wrap from entry DEPTH-1 back to entry 0. Playing an entry does not change it, so repeated passes around the ring return the same data.
- R7: For each play command, rd_vld is high for exactly one cycle. That cycle follows the L-th rising edge after the edge that sampled the command. L is cfg_rd_lat, with 0 treated as 1 and values above MAX_LAT treated as MAX_LAT.
- R8: rd_data is all zeros in every cycle where rd_vld is low.
- R9: A play command takes its data when it executes, one edge after it is sampled. A write-training command to the same entry sampled in the next cycle does not change the data already in flight. Later plays of that entry return the new data.
- R10: Nothing happens when cmd_vld is low or when cmd_op is 2'b00. No entry and no pointer changes, and no rd_vld is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code: 00 none, 01 load, 10 write-training, 11 play |
| cmd_addr | input | ADDR_W | Pattern bits for a load command |
| cmd_beat | input | $clog2(BURST) | Beat position written by a load command |
| wr_data | input | LANES*BURST | Write burst stored by a write-training command |
| cfg_rd_lat | input | $clog2(MAX_LAT+1) | Play latency in cycles, clamped to 1..MAX_LAT |
| rd_data | output | LANES*BURST | Played entry; zero while rd_vld is low |
| rd_vld | output | 1 | One-cycle strobe for each played entry |

## Verification
Two operations can act on the same entry in the same cycle window. A play can execute while a write-training command aimed at the entry being played is being sampled. Likewise, the output of one play can appear while the next play is entering the latency pipe. The bench brings the read pointer up to the write pointer, then issues a play immediately followed by a write to that same entry. It expects the old content on the output and the new content on the next pass around the ring. Back-to-back plays at the smallest and largest latency keep the pipe full; every output cycle is compared against a per-cycle schedule of expected strobes and data.

// File: rtl/lt_fifo_pkg.sv
package lt_fifo_pkg;

   typedef enum logic [1:0] {
      OP_NOP   = 2'b00,
      OP_LOAD  = 2'b01,
      OP_WRITE = 2'b10,
      OP_PLAY  = 2'b11
   } lt_op_e;

endpackage

// File: rtl/lt_cmd_reg.sv
module lt_cmd_reg
   import lt_fifo_pkg::*;
#(
   parameter int ADDR_W  = 14,
   parameter int BEAT_W  = 3,
   parameter int ENTRY_W = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_vld,
   input  logic [1:0]         cmd_op,
   input  logic [ADDR_W-1:0]  cmd_addr,
   input  logic [BEAT_W-1:0]  cmd_beat,
   input  logic [ENTRY_W-1:0] wr_data,
   output logic               ex_load,
   output logic               ex_write,
   output logic               ex_play,
   output logic [ADDR_W-1:0]  ex_addr,
   output logic [BEAT_W-1:0]  ex_beat,
   output logic [ENTRY_W-1:0] ex_data
);

   lt_op_e op;
   assign op = lt_op_e'(cmd_op);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ex_load  <= 1'b0;
         ex_write <= 1'b0;
         ex_play  <= 1'b0;
      end else begin
         ex_load  <= cmd_vld && (op == OP_LOAD);
         ex_write <= cmd_vld && (op == OP_WRITE);
         ex_play  <= cmd_vld && (op == OP_PLAY);
      end
   end

   always_ff @(posedge clk) begin
      if (cmd_vld) begin
         ex_addr <= cmd_addr;
         ex_beat <= cmd_beat;
         ex_data <= wr_data;
      end
   end

   // R10: at most one operation executes per cycle
   p_one_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ex_load, ex_write, ex_play}));

endmodule

// File: rtl/lt_store.sv
module lt_store #(
   parameter int DEPTH  = 6,
   parameter int LANES  = 32,
   parameter int BURST  = 8,
   parameter int ADDR_W = 14,
   localparam int ENTRY_W = LANES * BURST,
   localparam int BEAT_W  = $clog2(BURST),
   localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ex_load,
   input  logic               ex_write,
   input  logic               ex_play,
   input  logic [ADDR_W-1:0]  ex_addr,
   input  logic [BEAT_W-1:0]  ex_beat,
   input  logic [ENTRY_W-1:0] ex_data,
   output logic [ENTRY_W-1:0] rd_entry,
   output logic [PTR_W-1:0]   wptr,
   output logic [PTR_W-1:0]   rptr
);

   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [LANES-1:0]   pat;
   logic [PTR_W-1:0]   wnext;
   logic [PTR_W-1:0]   rnext;
   logic               w_adv;

   // address bits repeat across the lanes of one beat
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign pat[i] = ex_addr[i % ADDR_W];
   end

   if ((2 ** PTR_W) == DEPTH) begin : g_pow2
      assign wnext = wptr + 1'b1;
      assign rnext = rptr + 1'b1;
   end else begin : g_mod
      assign wnext = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      assign rnext = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
   end

   assign w_adv = ex_write || (ex_load && (ex_beat == BEAT_W'(BURST - 1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (w_adv)   wptr <= wnext;
         if (ex_play) rptr <= rnext;
      end
   end

   always_ff @(posedge clk) begin
      if (ex_write) begin
         mem[wptr] <= ex_data;
      end else if (ex_load) begin
         mem[wptr][ex_beat * LANES +: LANES] <= pat;
      end
   end

   assign rd_entry = mem[rptr];

   // R6: pointers stay inside the ring and wrap to zero
   p_wptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(wptr) < DEPTH) && (int'(rptr) < DEPTH));

   p_wptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (w_adv && int'(wptr) == DEPTH - 1) |=> (wptr == '0));

   // R5: each play moves the read pointer by exactly one
   p_rptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_play && int'(rptr) == DEPTH - 1) |=> (rptr == '0));

   p_rptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_play && int'(rptr) < DEPTH - 1) |=> (int'(rptr) == int'($past(rptr)) + 1));

   // R4: a load to any beat but the last keeps the write pointer
   p_load_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_load && ex_beat != BEAT_W'(BURST - 1)) |=> $stable(wptr));

endmodule

// File: rtl/lt_lat_pipe.sv
module lt_lat_pipe #(
   parameter int W       = 256,
   parameter int MAX_LAT = 8,
   localparam int LAT_W  = $clog2(MAX_LAT + 1),
   localparam int IDX_W  = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [W-1:0]     in_data,
   input  logic [LAT_W-1:0] cfg_lat,
   output logic             out_vld,
   output logic [W-1:0]     out_data
);

   logic             sv [MAX_LAT];
   logic [W-1:0]     sd [MAX_LAT];
   logic [LAT_W-1:0] lat_eff;
   logic [IDX_W-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < MAX_LAT; k++) sv[k] <= 1'b0;
      end else begin
         sv[0] <= in_vld;
         for (int k = 1; k < MAX_LAT; k++) sv[k] <= sv[k-1];
      end
   end

   always_ff @(posedge clk) begin
      sd[0] <= in_data;
      for (int k = 1; k < MAX_LAT; k++) sd[k] <= sd[k-1];
   end

   always_comb begin
      if (cfg_lat == '0)                      lat_eff = LAT_W'(1);
      else if (cfg_lat > LAT_W'(MAX_LAT))     lat_eff = LAT_W'(MAX_LAT);
      else                                    lat_eff = cfg_lat;
   end

   assign idx      = IDX_W'(lat_eff - 1'b1);
   assign out_vld  = sv[idx];
   assign out_data = sv[idx] ? sd[idx] : '0;

   // R7: no strobe can leave an empty pipe
   p_empty_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_vld && $stable(cfg_lat) && !out_vld && !sv[0]
       && (lat_eff == LAT_W'(1))) |=> !out_vld);

endmodule

// File: rtl/lt_read_fifo.sv
module lt_read_fifo
   import lt_fifo_pkg::*;
#(
   parameter int DEPTH   = 6,
   parameter int LANES   = 32,
   parameter int BURST   = 8,
   parameter int ADDR_W  = 14,
   parameter int MAX_LAT = 8,
   localparam int BEAT_W  = $clog2(BURST),
   localparam int ENTRY_W = LANES * BURST,
   localparam int LAT_W   = $clog2(MAX_LAT + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_vld,
   input  logic [1:0]         cmd_op,
   input  logic [ADDR_W-1:0]  cmd_addr,
   input  logic [BEAT_W-1:0]  cmd_beat,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic [LAT_W-1:0]   cfg_rd_lat,
   output logic [ENTRY_W-1:0] rd_data,
   output logic               rd_vld
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("lt_read_fifo: DEPTH must be at least 2");
   end
   if (BURST < 2 || (2 ** BEAT_W) != BURST) begin : g_bad_burst
      $error("lt_read_fifo: BURST must be a power of two of at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > LANES) begin : g_bad_addr
      $error("lt_read_fifo: ADDR_W must lie in 1..LANES");
   end
   if (MAX_LAT < 1) begin : g_bad_lat
      $error("lt_read_fifo: MAX_LAT must be at least 1");
   end

   logic               ex_load, ex_write, ex_play;
   logic [ADDR_W-1:0]  ex_addr;
   logic [BEAT_W-1:0]  ex_beat;
   logic [ENTRY_W-1:0] ex_data;
   logic [ENTRY_W-1:0] rd_entry;
   logic [PTR_W-1:0]   wptr, rptr;

   lt_cmd_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .ENTRY_W(ENTRY_W)) u_dec (
      .clk(clk), .rst_n(rst_n),
      .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .cmd_beat(cmd_beat), .wr_data(wr_data),
      .ex_load(ex_load), .ex_write(ex_write), .ex_play(ex_play),
      .ex_addr(ex_addr), .ex_beat(ex_beat), .ex_data(ex_data)
   );

   lt_store #(.DEPTH(DEPTH), .LANES(LANES), .BURST(BURST), .ADDR_W(ADDR_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .ex_load(ex_load), .ex_write(ex_write), .ex_play(ex_play),
      .ex_addr(ex_addr), .ex_beat(ex_beat), .ex_data(ex_data),
      .rd_entry(rd_entry), .wptr(wptr), .rptr(rptr)
   );

   lt_lat_pipe #(.W(ENTRY_W), .MAX_LAT(MAX_LAT)) u_pipe (
      .clk(clk), .rst_n(rst_n),
      .in_vld(ex_play), .in_data(rd_entry), .cfg_lat(cfg_rd_lat),
      .out_vld(rd_vld), .out_data(rd_data)
   );

   // R10: a cycle without a real command leaves both pointers alone
   p_idle_ptrs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cmd_vld) || $past(cmd_op) == 2'b00) |=> ($stable(wptr) && $stable(rptr)));

endmodule

// File: tb/lt_read_fifo_bench.sv
`timescale 1ns/1ps
module lt_read_fifo_bench;

   localparam int DEPTH   = 6;
   localparam int LANES   = 32;
   localparam int BURST   = 8;
   localparam int ADDR_W  = 14;
   localparam int MAX_LAT = 8;
   localparam int BEAT_W  = $clog2(BURST);
   localparam int ENTRY_W = LANES * BURST;
   localparam int LAT_W   = $clog2(MAX_LAT + 1);

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cmd_vld = 1'b0;
   logic [1:0]         cmd_op = 2'b00;
   logic [ADDR_W-1:0]  cmd_addr = '0;
   logic [BEAT_W-1:0]  cmd_beat = '0;
   logic [ENTRY_W-1:0] wr_data = '0;
   logic [LAT_W-1:0]   cfg_rd_lat = LAT_W'(1);
   logic [ENTRY_W-1:0] rd_data;
   logic               rd_vld;

   lt_read_fifo #(.DEPTH(DEPTH), .LANES(LANES), .BURST(BURST),
                  .ADDR_W(ADDR_W), .MAX_LAT(MAX_LAT)) u_lt_read_fifo (
      .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_beat(cmd_beat), .wr_data(wr_data),
      .cfg_rd_lat(cfg_rd_lat), .rd_data(rd_data), .rd_vld(rd_vld)
   );

   always #4 clk = ~clk;

   int    checks = 0;
   int    errors = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   bit    mon_on = 1'b0;
   string cur_req = "R1";

   logic               exp_v [64];
   logic [ENTRY_W-1:0] exp_d [64];
   logic [ENTRY_W-1:0] model [DEPTH];
   int wp = 0;
   int rp = 0;
   int lat_cfg = 1;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int eff_lat(int c);
      if (c == 0) return 1;
      if (c > MAX_LAT) return MAX_LAT;
      return c;
   endfunction

   function automatic logic [ENTRY_W-1:0] wpat(int k);
      logic [ENTRY_W-1:0] r;
      for (int b = 0; b < BURST; b++)
         r[b*LANES +: LANES] = LANES'(32'hC3A5_0000 ^ (k * 32'h1000_0001) ^ (b * 32'h0101_0101));
      return r;
   endfunction

   function automatic logic [ADDR_W-1:0] lpat(int e, int b);
      return ADDR_W'(((e * 8 + b) * 32'h0123) ^ 32'h02A5);
   endfunction

   task automatic chk(bit ok, string req, logic [ENTRY_W-1:0] act, logic [ENTRY_W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // per-cycle comparison of strobe and data against the schedule
   always @(negedge clk) begin
      if (rst_n && mon_on) begin
         int s;
         s = cyc % 64;
         if (rd_vld !== exp_v[s])
            chk(1'b0, {cur_req, "/R7 strobe"}, ENTRY_W'(rd_vld), ENTRY_W'(exp_v[s]));
         else if (exp_v[s])
            chk(rd_data === exp_d[s], {cur_req, "/R5 data"}, rd_data, exp_d[s]);
         else
            chk(rd_data === '0, {cur_req, "/R8 idle data"}, rd_data, '0);
         exp_v[s] = 1'b0;
      end
   end

   task automatic send(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                       input int b, input logic [ENTRY_W-1:0] d);
      cmd_vld  = 1'b1;
      cmd_op   = op;
      cmd_addr = a;
      cmd_beat = BEAT_W'(b);
      wr_data  = d;
      if (op == 2'b01) begin
         for (int i = 0; i < LANES; i++) model[wp][b*LANES + i] = a[i % ADDR_W];
         if (b == BURST - 1) wp = (wp + 1) % DEPTH;
      end else if (op == 2'b10) begin
         model[wp] = d;
         wp = (wp + 1) % DEPTH;
      end else if (op == 2'b11) begin
         int s;
         s = (cyc + 1 + eff_lat(lat_cfg)) % 64;
         exp_v[s] = 1'b1;
         exp_d[s] = model[rp];
         rp = (rp + 1) % DEPTH;
      end
      @(negedge clk);
   endtask

   task automatic idle(int n);
      cmd_vld = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic set_lat(int c);
      lat_cfg    = c;
      cfg_rd_lat = LAT_W'(c);
   endtask

   task automatic play(int n);
      for (int k = 0; k < n; k++) send(2'b11, '0, 0, '0);
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R7 watchdog act=running exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      for (int s = 0; s < 64; s++) begin
         exp_v[s] = 1'b0;
         exp_d[s] = '0;
      end
      for (int e = 0; e < DEPTH; e++) model[e] = '0;

      // R1: outputs quiet during and right after reset
      repeat (3) @(negedge clk);
      chk(rd_vld === 1'b0, "R1 vld in reset", ENTRY_W'(rd_vld), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rd_vld === 1'b0 && rd_data === '0, "R1 after reset", rd_data, '0);
      mon_on = 1'b1;

      // R2 R5 R6: fill every entry, then replay the ring twice
      cur_req = "R2";
      set_lat(3);
      for (int k = 0; k < DEPTH; k++) send(2'b10, '0, 0, wpat(k));
      idle(2);
      cur_req = "R6";
      play(2 * DEPTH);
      idle(MAX_LAT + 3);

      // R3 R4: partial load of entry 0, beat 3 then the last beat
      cur_req = "R3";
      send(2'b01, lpat(9, 3), 3, '0);
      send(2'b01, lpat(9, 7), BURST - 1, '0);
      idle(1);
      play(1);
      idle(MAX_LAT + 3);

      // R4: full beat sweep of the remaining entries
      cur_req = "R4";
      for (int e = 1; e < DEPTH; e++)
         for (int b = 0; b < BURST; b++) send(2'b01, lpat(e, b), b, '0);
      idle(1);
      play(DEPTH - 1);
      idle(MAX_LAT + 3);

      // R7: latency sweep across every code, clamping included
      cur_req = "R7";
      for (int c = 0; c < 16; c++) begin
         set_lat(c);
         idle(1);
         play(1);
         idle(MAX_LAT + 3);
      end
      set_lat(1);
      idle(1);
      play(DEPTH + 2);
      idle(MAX_LAT + 3);
      set_lat(MAX_LAT);
      idle(1);
      play(DEPTH + 2);
      idle(MAX_LAT + 3);

      // R9: play immediately followed by a write to the same entry
      cur_req = "R9";
      set_lat(4);
      idle(1);
      while (rp != wp) play(1);
      send(2'b11, '0, 0, '0);
      send(2'b10, '0, 0, wpat(77));
      idle(1);
      play(DEPTH);
      idle(MAX_LAT + 3);

      // R10: strobe low with a play code, and strobe high with the no-op code
      cur_req = "R10";
      cmd_vld  = 1'b0;
      cmd_op   = 2'b11;
      wr_data  = wpat(99);
      repeat (3) @(negedge clk);
      cmd_op = 2'b10;
      repeat (3) @(negedge clk);
      for (int k = 0; k < 3; k++) send(2'b00, lpat(5, 5), 5, wpat(55));
      idle(MAX_LAT + 2);
      play(DEPTH);
      idle(MAX_LAT + 3);

      // R1: reset in mid-run returns both pointers to entry 0
      cur_req = "R1";
      send(2'b10, '0, 0, wpat(31));
      idle(MAX_LAT + 3);
      mon_on = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk(rd_vld === 1'b0, "R1 vld in second reset", ENTRY_W'(rd_vld), '0);
      @(negedge clk);
      rst_n = 1'b1;
      wp = 0;
      rp = 0;
      for (int s = 0; s < 64; s++) exp_v[s] = 1'b0;
      @(negedge clk);
      mon_on = 1'b1;
      send(2'b10, '0, 0, wpat(44));
      idle(1);
      play(DEPTH);
      idle(MAX_LAT + 3);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule